// File: doc/BRIEF.md
# Paged Effective Address Generator

This block produces the physical word address used by load and store instructions. The caller supplies a 20-bit address field, the number and value of an index register, and the status word. The block works out a 20-bit offset in one of four addressing modes. It then places the process page number, taken from the status word, above that offset. The result is a 26-bit address for the memory address register. All offset arithmetic wraps inside the 20-bit page, so a program can only ever reach the one page that its status word names.

Direct and indexed modes finish in the cycle after the request. The two indirect modes first read a pointer word from memory through a request/acknowledge handshake. The indexed-indirect mode adds the index before that read. The low 20 bits of the returned word become the final offset. A one-cycle done pulse marks the moment the final address is valid.

The controller has two states. ST_IDLE accepts a start. It moves to ST_FETCH on an indirect mode and otherwise stays in ST_IDLE, completing the request at once. ST_FETCH holds the pointer read request until the acknowledge arrives, then returns to ST_IDLE.

Top module: `paged_ea_gen`

## Requirements
- R1: With mode 2'b00 (direct), a start accepted in ST_IDLE gives done high in the next cycle with phys_addr = {page, addr_field}.
- R2: With mode 2'b10 (indexed), the offset is addr_field plus the low 20 bits of idx_value, and done follows one cycle after start.
- R3: Index register number 0 reads as zero whatever idx_value holds. Indexed mode then acts as direct mode, and indexed-indirect mode acts as indirect mode.
- R4: With mode 2'b01 (indirect), the cycle after start shows mem_req high with mem_addr = {page, addr_field}. mem_req and mem_addr stay unchanged until mem_ack is seen.
- R5: With mode 2'b11 (indexed-indirect), the pointer read address is {page, addr_field + idx_value[19:0]}. The index is added before the read.
- R6: In the indirect modes, the cycle after mem_ack shows done high, mem_req low, and phys_addr = {page latched at start, mem_rdata[19:0]}. Status changes during the read have no effect.
- R7: The page number is status_word bits 21:16 and goes to phys_addr bits 25:20; all other status bits have no effect.
- R8: Offset sums wrap modulo 2^20 and never carry into the page bits.
- R9: A start while busy (ST_FETCH) is ignored: it produces no done and does not disturb the pending read.
- R10: After reset, done, mem_req and busy are low and phys_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new address (accepted only when not busy) |
| mode | input | 2 | 00 direct, 01 indirect, 10 indexed, 11 indexed-indirect |
| addr_field | input | 20 | Address field of the instruction |
| idx_num | input | 3 | Index register number; 0 means zero index |
| idx_value | input | 32 | Contents of the selected index register |
| status_word | input | 32 | Status register; bits 21:16 hold the page |
| mem_req | output | 1 | Pointer read request, held until acknowledged |
| mem_addr | output | 26 | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge, returns mem_rdata |
| mem_rdata | input | 32 | Pointer word read from memory |
| busy | output | 1 | High while a pointer read is outstanding |
| done | output | 1 | One-cycle pulse: phys_addr is valid |
| phys_addr | output | 26 | Final physical address, held until the next result |

## Verification
The hardest situation to reach is a start pulse, or a change of the status page, that arrives while a pointer read is still outstanding. The bench reaches it by acting as the memory itself. It holds off the acknowledge for several cycles, and during that window it pulses start in direct mode and rewrites the status page. The scoreboard then shows that no extra result appears. It also shows that the final address keeps the page latched at the start.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int OFS_W    = 20;
    localparam int PAGE_W   = 6;
    localparam int WORD_W   = 32;
    localparam int IDX_W    = 3;
    localparam int PAGE_LSB = 16;

    // mode[0]: pointer fetch, mode[1]: add index
    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_INDIRECT = 2'b01,
        MODE_INDEXED  = 2'b10,
        MODE_IDX_IND  = 2'b11
    } ea_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc #(
    parameter int OFS_W  = 20,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic [OFS_W-1:0]  addr_field,
    input  logic [IDX_W-1:0]  idx_num,
    input  logic [WORD_W-1:0] idx_value,
    input  logic              use_index,
    output logic [OFS_W-1:0]  offset
);
    logic [OFS_W-1:0] idx_low;
    logic [OFS_W-1:0] idx_eff;

    generate
        if (WORD_W > OFS_W) begin : g_trunc
            logic idx_high_unused;
            assign idx_low         = idx_value[OFS_W-1:0];
            assign idx_high_unused = ^idx_value[WORD_W-1:OFS_W];
        end else if (WORD_W == OFS_W) begin : g_same
            assign idx_low = idx_value;
        end else begin : g_extend
            assign idx_low = {{(OFS_W-WORD_W){1'b0}}, idx_value};
        end
    endgenerate

    // register number zero is hardwired to the constant zero
    always_comb begin
        if (use_index && (idx_num != '0)) begin
            idx_eff = idx_low;
        end else begin
            idx_eff = '0;
        end
    end

    // natural width truncation gives modulo 2^OFS_W wrap
    assign offset = addr_field + idx_eff;
endmodule

// File: rtl/ea_page_join.sv
module ea_page_join #(
    parameter int OFS_W    = 20,
    parameter int PAGE_W   = 6,
    parameter int WORD_W   = 32,
    parameter int PAGE_LSB = 16
) (
    input  logic [WORD_W-1:0]       status_word,
    input  logic [OFS_W-1:0]        offset,
    output logic [PAGE_W-1:0]       page,
    output logic [PAGE_W+OFS_W-1:0] phys
);
    localparam logic [WORD_W-1:0] PAGE_MASK =
        {{(WORD_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}} << PAGE_LSB;

    logic status_other_unused;

    assign page                = status_word[PAGE_LSB +: PAGE_W];
    assign status_other_unused = ^(status_word & ~PAGE_MASK);
    assign phys                = {page, offset};
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int OFS_W  = 20,
    parameter int PAGE_W = 6,
    localparam int PHYS_W = OFS_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fetch_mode,
    input  logic [PHYS_W-1:0] calc_phys,
    input  logic              mem_ack,
    input  logic [OFS_W-1:0]  ptr_offset,
    output logic              mem_req,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic [PHYS_W-1:0] phys_addr
);
    ea_state_e         st_q, st_nxt;
    logic [PHYS_W-1:0] req_addr_q;
    logic [PHYS_W-1:0] phys_q;
    logic              done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start && fetch_mode) begin
                    st_nxt = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q <= '0;
            phys_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (fetch_mode) begin
                            req_addr_q <= calc_phys;
                        end else begin
                            phys_q <= calc_phys;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        phys_q <= {req_addr_q[PHYS_W-1:OFS_W], ptr_offset};
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_req   = (st_q == ST_FETCH);
    assign busy      = (st_q != ST_IDLE);
    assign mem_addr  = req_addr_q;
    assign done      = done_q;
    assign phys_addr = phys_q;
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
    import ea_pkg::*;
#(
    parameter int OFS_W    = ea_pkg::OFS_W,
    parameter int PAGE_W   = ea_pkg::PAGE_W,
    parameter int WORD_W   = ea_pkg::WORD_W,
    parameter int IDX_W    = ea_pkg::IDX_W,
    parameter int PAGE_LSB = ea_pkg::PAGE_LSB,
    localparam int PHYS_W  = OFS_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [OFS_W-1:0]  addr_field,
    input  logic [IDX_W-1:0]  idx_num,
    input  logic [WORD_W-1:0] idx_value,
    input  logic [WORD_W-1:0] status_word,
    output logic              mem_req,
    output logic [PHYS_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [PHYS_W-1:0] phys_addr
);
    ea_mode_e          mode_e;
    logic              use_index;
    logic              fetch_mode;
    logic [OFS_W-1:0]  offset;
    logic [PAGE_W-1:0] page;
    logic [PHYS_W-1:0] calc_phys;
    logic [OFS_W-1:0]  ptr_offset;

    assign mode_e     = ea_mode_e'(mode);
    assign use_index  = (mode_e == MODE_INDEXED) || (mode_e == MODE_IDX_IND);
    assign fetch_mode = (mode_e == MODE_INDIRECT) || (mode_e == MODE_IDX_IND);

    generate
        if (WORD_W > OFS_W) begin : g_ptr_trunc
            logic ptr_high_unused;
            assign ptr_offset      = mem_rdata[OFS_W-1:0];
            assign ptr_high_unused = ^mem_rdata[WORD_W-1:OFS_W];
        end else begin : g_ptr_ext
            assign ptr_offset = OFS_W'(mem_rdata);
        end
    endgenerate

    ea_offset_calc #(
        .OFS_W (OFS_W),
        .WORD_W(WORD_W),
        .IDX_W (IDX_W)
    ) u_ofs (
        .addr_field(addr_field),
        .idx_num   (idx_num),
        .idx_value (idx_value),
        .use_index (use_index),
        .offset    (offset)
    );

    ea_page_join #(
        .OFS_W   (OFS_W),
        .PAGE_W  (PAGE_W),
        .WORD_W  (WORD_W),
        .PAGE_LSB(PAGE_LSB)
    ) u_join (
        .status_word(status_word),
        .offset     (offset),
        .page       (page),
        .phys       (calc_phys)
    );

    ea_ctrl #(
        .OFS_W (OFS_W),
        .PAGE_W(PAGE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fetch_mode(fetch_mode),
        .calc_phys (calc_phys),
        .mem_ack   (mem_ack),
        .ptr_offset(ptr_offset),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .phys_addr (phys_addr)
    );
endmodule

// File: rtl/ea_checker.sv
module ea_checker #(
    parameter int OFS_W    = 20,
    parameter int PAGE_W   = 6,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 3,
    parameter int PAGE_LSB = 16,
    localparam int PHYS_W  = OFS_W + PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        mode,
    input logic [OFS_W-1:0]  addr_field,
    input logic [IDX_W-1:0]  idx_num,
    input logic [WORD_W-1:0] status_word,
    input logic              mem_req,
    input logic [PHYS_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              busy,
    input logic              done,
    input logic [PHYS_W-1:0] phys_addr
);
    assert_direct_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 2'b00) |=>
            (done && phys_addr == {$past(status_word[PAGE_LSB +: PAGE_W]), $past(addr_field)}));

    assert_zero_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 2'b10 && idx_num == '0) |=>
            (done && phys_addr[OFS_W-1:0] == $past(addr_field)));

    assert_fetch_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 2'b01) |=>
            (mem_req && mem_addr == {$past(status_word[PAGE_LSB +: PAGE_W]), $past(addr_field)}));

    assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_pointer_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=>
            (done && !mem_req
             && phys_addr[OFS_W-1:0] == $past(mem_rdata[OFS_W-1:0])
             && phys_addr[PHYS_W-1:OFS_W] == $past(mem_addr[PHYS_W-1:OFS_W])));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_ack) |=> !done);
endmodule

bind paged_ea_gen ea_checker #(
    .OFS_W   (OFS_W),
    .PAGE_W  (PAGE_W),
    .WORD_W  (WORD_W),
    .IDX_W   (IDX_W),
    .PAGE_LSB(PAGE_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .addr_field (addr_field),
    .idx_num    (idx_num),
    .status_word(status_word),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .phys_addr  (phys_addr)
);

// File: tb/paged_ea_gen_test.sv
module paged_ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [19:0] addr_field = '0;
    logic [2:0]  idx_num = '0;
    logic [31:0] idx_value = '0;
    logic [31:0] status_word = '0;
    logic        mem_req;
    logic [25:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        done;
    logic [25:0] phys_addr;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    paged_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .idx_num(idx_num), .idx_value(idx_value),
        .status_word(status_word), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .phys_addr(phys_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] status_for(input logic [5:0] pg, input logic [31:0] noise);
        return (noise & ~32'h003F_0000) | ({26'd0, pg} << 16);
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                done_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", {6'd0, phys_addr}, 32'h0);
                end else begin
                    logic [25:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(phys_addr == e, t, {6'd0, phys_addr}, {6'd0, e});
                end
            end
        end
    end

    task automatic issue_fast(input logic [1:0] m, input logic [19:0] f,
                              input logic [2:0] xn, input logic [31:0] xv,
                              input logic [31:0] st, input logic [25:0] e,
                              input string tag);
        @(negedge clk);
        start = 1'b1; mode = m; addr_field = f; idx_num = xn; idx_value = xv;
        status_word = st;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic issue_ptr(input logic [1:0] m, input logic [19:0] f,
                             input logic [2:0] xn, input logic [31:0] xv,
                             input logic [31:0] st, input logic [25:0] e_addr,
                             input logic [31:0] ptr, input int wait_n,
                             input bit poke, input logic [25:0] e_final,
                             input string tag);
        @(negedge clk);
        start = 1'b1; mode = m; addr_field = f; idx_num = xn; idx_value = xv;
        status_word = st;
        @(negedge clk);
        start = 1'b0;
        check(mem_req == 1'b1, {tag, " mem_req raised"}, {31'd0, mem_req}, 32'd1);
        check(mem_addr == e_addr, {tag, " pointer address"}, {6'd0, mem_addr}, {6'd0, e_addr});
        for (int k = 0; k < wait_n; k++) begin
            if (poke && k == 1) begin
                // R9: start while busy; R6: page changes mid-read
                start = 1'b1; mode = 2'b00; addr_field = 20'hDEAD0;
                status_word = status_for(6'h3E, 32'h0);
            end
            @(negedge clk);
            start = 1'b0;
            check(mem_req && busy, {tag, " request held"}, {30'd0, mem_req, busy}, 32'd3);
            check(mem_addr == e_addr, {tag, " address stable"}, {6'd0, mem_addr}, {6'd0, e_addr});
        end
        exp_q.push_back(e_final); tag_q.push_back(tag);
        mem_ack = 1'b1; mem_rdata = ptr;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'h0;
        check(mem_req == 1'b0, {tag, " request released"}, {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R10 done after reset", {31'd0, done}, 32'd0);
        check(mem_req == 1'b0, "R10 mem_req after reset", {31'd0, mem_req}, 32'd0);
        check(busy == 1'b0, "R10 busy after reset", {31'd0, busy}, 32'd0);
        check(phys_addr == '0, "R10 phys_addr after reset", {6'd0, phys_addr}, 32'd0);
        rst_n = 1'b1;

        // R1 R7: the worked page example with every other status bit set
        issue_fast(2'b00, 20'h54321, 3'd4, 32'hFFFF_FFFF, status_for(6'h17, 32'hFFFF_FFFF),
                   26'h1754321, "R1 R7 direct page 0x17");
        issue_fast(2'b00, 20'hFFFFF, 3'd0, 32'h0, status_for(6'h00, 32'h0),
                   26'h00FFFFF, "R1 direct page 0");
        issue_fast(2'b10, 20'h10000, 3'd5, 32'h0000_0234, status_for(6'h03, 32'h1234_0000),
                   26'h0310234, "R2 indexed");
        issue_fast(2'b10, 20'hFFFF0, 3'd7, 32'hABC0_0020, status_for(6'h3F, 32'h0),
                   26'h3F00010, "R8 indexed wrap");
        issue_fast(2'b10, 20'h00ABC, 3'd0, 32'h0001_2345, status_for(6'h01, 32'h0),
                   26'h0100ABC, "R3 indexed with register 0");

        issue_ptr(2'b01, 20'h00100, 3'd6, 32'h0000_0FFF, status_for(6'h05, 32'h0),
                  26'h0500100, 32'hFFF1_2345, 3, 1'b0, 26'h0512345, "R4 R6 indirect");
        issue_ptr(2'b11, 20'h20000, 3'd2, 32'h0000_0040, status_for(6'h09, 32'h0),
                  26'h0920040, 32'h000A_BCDE, 0, 1'b0, 26'h09ABCDE, "R5 indexed-indirect");
        issue_ptr(2'b11, 20'h00777, 3'd0, 32'h0005_5555, status_for(6'h0A, 32'h0),
                  26'h0A00777, 32'h0000_0001, 1, 1'b0, 26'h0A00001, "R3 indexed-indirect register 0");
        issue_ptr(2'b11, 20'hFFFFF, 3'd1, 32'h0000_0001, status_for(6'h02, 32'h0),
                  26'h0200000, 32'h0000_0007, 0, 1'b0, 26'h0200007, "R8 indexed-indirect wrap");
        issue_ptr(2'b01, 20'h00001, 3'd3, 32'h0, status_for(6'h04, 32'h0),
                  26'h0400001, 32'h0002_2222, 4, 1'b1, 26'h0422222, "R9 R6 start and page change while busy");

        issue_fast(2'b00, 20'h0ABCD, 3'd0, 32'h0, status_for(6'h21, 32'h0),
                   26'h210ABCD, "R1 direct after busy period");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results produced", exp_q.size(), 32'd0);
        check(done_seen == 11, "R9 done count", done_seen, 32'd11);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule